// File: doc/BRIEF.md
# Configurable Pad Interface Cell

This block is the programmable cell placed between one package pin and the core logic. Inbound, it hands the pin level to the core either straight through or via a capture flip-flop, which acts as a synchronizer. Outbound, it drives the pin either straight from the core or from a second flip-flop. Configuration inputs select each of these paths separately.

The driver has two modes. In three-state mode it drives the data with an enable drawn from a selectable source. In open-collector mode it can only pull the line low; when the data is high it releases the line.

The pin is modelled as three separate signals instead of a bidirectional port: the sensed level `padIn`, the driven level `padOut` and the drive enable `padOe`. The two flip-flops have their own clocks, `inClk` and `outClk`. They share one clock enable and one asynchronous reset.

Top module: `pad_cell`

## Requirements
- R1: With `cfgInReg` = 0, `coreIn` equals `padIn` combinationally, with no clock edge in between.
- R2: With `cfgInReg` = 1, `coreIn` takes the value of `padIn` at a rising edge of `inClk` on which `clkEn` = 1, and holds that value between such edges.
- R3: With `cfgOutReg` = 0, the outgoing data equals `coreOut` combinationally.
- R4: With `cfgOutReg` = 1, the outgoing data takes the value of `coreOut` at a rising edge of `outClk` on which `clkEn` = 1, and holds that value otherwise.
- R5: While `clkEn` = 0, neither flip-flop changes on its clock edge.
- R6: The two clocks are independent. The input flip-flop responds only to `inClk` and the output flip-flop only to `outClk`. While `outClk` is stopped, the registered output holds and the registered input keeps updating.
- R7: In three-state mode (`cfgOpenDrain` = 0), `padOut` equals the outgoing data. `padOe` follows `cfgOeSel`: 0 gives constant 1, 1 gives `coreOe`, 2 gives the inverse of `coreOe`, and 3 gives constant 0.
- R8: In open-collector mode (`cfgOpenDrain` = 1), `padOut` is always 0 and `padOe` is the inverse of the outgoing data. `cfgOeSel` and `coreOe` have no effect in this mode.
- R9: While `rstN` is low, both flip-flops are 0. This takes effect at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inClk | input | 1 | Clock of the input flip-flop |
| outClk | input | 1 | Clock of the output flip-flop |
| clkEn | input | 1 | Clock enable shared by both flip-flops |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgInReg | input | 1 | 1 selects the registered input path |
| cfgOutReg | input | 1 | 1 selects the registered output path |
| cfgOpenDrain | input | 1 | 1 selects open-collector drive, 0 selects three-state drive |
| cfgOeSel | input | 2 | Output-enable source for three-state mode |
| coreOut | input | 1 | Data from the core toward the pin |
| coreOe | input | 1 | Output enable from the core |
| padIn | input | 1 | Level sensed at the pin |
| coreIn | output | 1 | Pin data delivered to the core |
| padOut | output | 1 | Level driven onto the pin |
| padOe | output | 1 | Drive enable of the pin |

## Verification
The bench sweeps every combination of output-register mode, drive mode, enable source, core enable and data value. In registered mode it checks the pin both before and after the capturing edge. A cell that leaked `coreOut` past the output flip-flop would show the new value one edge too early. A cell that let the enable selection reach open-collector mode would drive the line with the enable flag instead of the data.

For the input path, the bench checks that the direct mode reacts with no edge and that the registered mode is still on the old value just before `inClk` rises. It also stops `outClk` while `inClk` keeps running. A cell with the clocks swapped or shared would then either move the frozen output or freeze the input. Finally, the reset is pulsed between edges, and a synchronous reset would leave both flip-flops holding 1.

// File: rtl/pad_pkg.sv
package pad_pkg;

  localparam int OE_SEL_W = 2;

  typedef enum logic [OE_SEL_W-1:0] {
    OE_ALWAYS   = 2'd0,
    OE_CORE     = 2'd1,
    OE_CORE_INV = 2'd2,
    OE_NEVER    = 2'd3
  } oeSel_e;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic inRegSel;
    logic outRegSel;
    logic drainMode;
    logic oeReq;
  } padStrobe_t;

endpackage

// File: rtl/pad_ctrl.sv
module pad_ctrl
  import pad_pkg::*;
(
  input  logic                cfgInReg,
  input  logic                cfgOutReg,
  input  logic                cfgOpenDrain,
  input  logic [OE_SEL_W-1:0] cfgOeSel,
  input  logic                coreOe,
  output padStrobe_t          strb
);

  oeSel_e oeSel;
  logic   oeReq;

  assign oeSel = oeSel_e'(cfgOeSel);

  always_comb begin
    unique case (oeSel)
      OE_ALWAYS:   oeReq = 1'b1;
      OE_CORE:     oeReq = coreOe;
      OE_CORE_INV: oeReq = ~coreOe;
      default:     oeReq = 1'b0;
    endcase
  end

  always_comb begin
    strb.inRegSel  = cfgInReg;
    strb.outRegSel = cfgOutReg;
    strb.drainMode = cfgOpenDrain;
    strb.oeReq     = oeReq;
  end

endmodule

// File: rtl/pad_datapath.sv
module pad_datapath
  import pad_pkg::*;
#(
  parameter logic RESET_LEVEL = 1'b0
) (
  input  logic       inClk,
  input  logic       outClk,
  input  logic       clkEn,
  input  logic       rstN,
  input  padStrobe_t strb,
  input  logic       coreOut,
  input  logic       padIn,
  output logic       coreIn,
  output logic       padOut,
  output logic       padOe
);

  logic inQ;
  logic outQ;
  logic outData;

  // input capture flop, doubles as synchronizer
  always_ff @(posedge inClk or negedge rstN) begin
    if (!rstN)      inQ <= RESET_LEVEL;
    else if (clkEn) inQ <= padIn;
  end

  // output launch flop
  always_ff @(posedge outClk or negedge rstN) begin
    if (!rstN)      outQ <= RESET_LEVEL;
    else if (clkEn) outQ <= coreOut;
  end

  assign coreIn  = strb.inRegSel  ? inQ  : padIn;
  assign outData = strb.outRegSel ? outQ : coreOut;

  // open-collector: only ever pull low
  assign padOut = strb.drainMode ? 1'b0     : outData;
  assign padOe  = strb.drainMode ? ~outData : strb.oeReq;

endmodule

// File: rtl/pad_cell.sv
module pad_cell
  import pad_pkg::*;
(
  input  logic                inClk,
  input  logic                outClk,
  input  logic                clkEn,
  input  logic                rstN,
  input  logic                cfgInReg,
  input  logic                cfgOutReg,
  input  logic                cfgOpenDrain,
  input  logic [OE_SEL_W-1:0] cfgOeSel,
  input  logic                coreOut,
  input  logic                coreOe,
  input  logic                padIn,
  output logic                coreIn,
  output logic                padOut,
  output logic                padOe
);

  padStrobe_t strb;

  pad_ctrl u_ctrl (
    .cfgInReg     (cfgInReg),
    .cfgOutReg    (cfgOutReg),
    .cfgOpenDrain (cfgOpenDrain),
    .cfgOeSel     (cfgOeSel),
    .coreOe       (coreOe),
    .strb         (strb)
  );

  pad_datapath #(.RESET_LEVEL(1'b0)) u_dp (
    .inClk   (inClk),
    .outClk  (outClk),
    .clkEn   (clkEn),
    .rstN    (rstN),
    .strb    (strb),
    .coreOut (coreOut),
    .padIn   (padIn),
    .coreIn  (coreIn),
    .padOut  (padOut),
    .padOe   (padOe)
  );

endmodule

// File: rtl/pad_cell_chk.sv
module pad_cell_chk
  import pad_pkg::*;
(
  input logic                inClk,
  input logic                outClk,
  input logic                clkEn,
  input logic                rstN,
  input logic                cfgInReg,
  input logic                cfgOutReg,
  input logic                cfgOpenDrain,
  input logic [OE_SEL_W-1:0] cfgOeSel,
  input logic                coreOut,
  input logic                coreOe,
  input logic                padIn,
  input logic                coreIn,
  input logic                padOut,
  input logic                padOe
);

  // R1
  in_direct_chk: assert property (@(posedge inClk) disable iff (!rstN)
    !cfgInReg |-> coreIn == padIn);

  // R2
  in_capture_chk: assert property (@(posedge inClk) disable iff (!rstN)
    cfgInReg && clkEn |=> (!cfgInReg || coreIn == $past(padIn)));

  // R5
  in_hold_chk: assert property (@(posedge inClk) disable iff (!rstN)
    cfgInReg && !clkEn |=> (!cfgInReg || $stable(coreIn)));

  // R3
  out_direct_chk: assert property (@(posedge outClk) disable iff (!rstN)
    !cfgOutReg && !cfgOpenDrain |-> padOut == coreOut);

  // R4
  out_capture_chk: assert property (@(posedge outClk) disable iff (!rstN)
    cfgOutReg && clkEn && !cfgOpenDrain |=>
      (!cfgOutReg || cfgOpenDrain || padOut == $past(coreOut)));

  // R7
  oe_always_chk: assert property (@(posedge outClk) disable iff (!rstN)
    !cfgOpenDrain && cfgOeSel == 2'd0 |-> padOe);

  // R7
  oe_never_chk: assert property (@(posedge outClk) disable iff (!rstN)
    !cfgOpenDrain && cfgOeSel == 2'd3 |-> !padOe);

  // R7
  oe_core_chk: assert property (@(posedge outClk) disable iff (!rstN)
    !cfgOpenDrain && cfgOeSel == 2'd1 |-> padOe == coreOe);

  // R8
  drain_low_chk: assert property (@(posedge outClk) disable iff (!rstN)
    cfgOpenDrain |-> !padOut);

  // R8
  drain_oe_chk: assert property (@(posedge outClk) disable iff (!rstN)
    cfgOpenDrain && !cfgOutReg |-> padOe == !coreOut);

endmodule

bind pad_cell pad_cell_chk u_chk (
  .inClk        (inClk),
  .outClk       (outClk),
  .clkEn        (clkEn),
  .rstN         (rstN),
  .cfgInReg     (cfgInReg),
  .cfgOutReg    (cfgOutReg),
  .cfgOpenDrain (cfgOpenDrain),
  .cfgOeSel     (cfgOeSel),
  .coreOut      (coreOut),
  .coreOe       (coreOe),
  .padIn        (padIn),
  .coreIn       (coreIn),
  .padOut       (padOut),
  .padOe        (padOe)
);

// File: tb/tb_pad_cell.sv
module tb_pad_cell;

  logic inClk = 1'b0;
  logic outClk = 1'b0;
  logic outRun = 1'b1;
  logic clkEn, rstN, cfgInReg, cfgOutReg, cfgOpenDrain, coreOut, coreOe, padIn;
  logic [1:0] cfgOeSel;
  logic coreIn, padOut, padOe;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  pad_cell dut (
    .inClk(inClk), .outClk(outClk), .clkEn(clkEn), .rstN(rstN),
    .cfgInReg(cfgInReg), .cfgOutReg(cfgOutReg), .cfgOpenDrain(cfgOpenDrain),
    .cfgOeSel(cfgOeSel), .coreOut(coreOut), .coreOe(coreOe), .padIn(padIn),
    .coreIn(coreIn), .padOut(padOut), .padOe(padOe)
  );

  // 50 MHz; outClk stays in phase and can be frozen low
  always #10 begin
    inClk = ~inClk;
    if (outRun) outClk = ~outClk;
  end

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expOe(input logic [1:0] sel, input logic oe);
    case (sel)
      2'd0: return 1'b1;
      2'd1: return oe;
      2'd2: return ~oe;
      default: return 1'b0;
    endcase
  endfunction

  task automatic chkPad(input string req, input logic data, input logic od,
                        input logic [1:0] sel, input logic oe);
    chk(req, padOut, od ? 1'b0 : data);
    chk(req, padOe, od ? ~data : expOe(sel, oe));
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rstN = 0; clkEn = 1; cfgInReg = 1; cfgOutReg = 1; cfgOpenDrain = 0;
    cfgOeSel = 2'd0; coreOut = 1; coreOe = 0; padIn = 1;
    repeat (2) @(posedge inClk);
    #1;
    // R9: both flops hold 0 in reset despite ones at their inputs
    chk("R9 reset coreIn", coreIn, 1'b0);
    chk("R9 reset padOut", padOut, 1'b0);
    @(negedge inClk);
    rstN = 1; padIn = 0; coreOut = 0;
    @(posedge inClk); #1;

    // R1: direct input, no clock edge
    @(negedge inClk);
    cfgInReg = 0;
    for (int v = 0; v < 2; v++) begin
      padIn = v[0]; #1;
      chk("R1 direct input", coreIn, v[0]);
    end

    // R2: registered input lags to next edge
    @(negedge inClk);
    cfgInReg = 1; padIn = 0;
    @(posedge inClk); #1;
    @(negedge inClk);
    padIn = 1; #1;
    chk("R2 before edge", coreIn, 1'b0);
    @(posedge inClk); #1;
    chk("R2 after edge", coreIn, 1'b1);

    // R5: clkEn low freezes both flops
    @(negedge inClk);
    clkEn = 0; padIn = 0; cfgOutReg = 1; coreOut = 1;
    @(posedge inClk); #1;
    chk("R5 input hold", coreIn, 1'b1);
    chk("R5 output hold", padOut, 1'b0);
    @(negedge inClk);
    clkEn = 1;
    @(posedge inClk); #1;
    chk("R5 input resume", coreIn, 1'b0);
    chk("R5 output resume", padOut, 1'b1);

    // R3 R4 R7 R8: exhaustive sweep of output modes
    for (int r = 0; r < 2; r++)
      for (int d = 0; d < 2; d++)
        for (int s = 0; s < 4; s++)
          for (int o = 0; o < 2; o++)
            for (int v = 0; v < 2; v++) begin
              @(negedge inClk);
              cfgOutReg = r[0]; cfgOpenDrain = d[0]; cfgOeSel = s[1:0];
              coreOe = o[0]; coreOut = ~v[0];
              @(posedge inClk); #1;
              @(negedge inClk);
              coreOut = v[0]; #1;
              if (r == 0) begin
                chkPad(d ? "R8 direct" : "R3 R7 direct", v[0], d[0], s[1:0], o[0]);
              end else begin
                chkPad(d ? "R8 pre-edge" : "R4 R7 pre-edge", ~v[0], d[0], s[1:0], o[0]);
                @(posedge inClk); #1;
                chkPad(d ? "R8 post-edge" : "R4 R7 post-edge", v[0], d[0], s[1:0], o[0]);
              end
            end

    // R6: stop outClk, keep inClk
    @(negedge inClk);
    cfgOutReg = 1; cfgOpenDrain = 0; cfgOeSel = 2'd0; coreOut = 0; padIn = 0;
    @(posedge inClk); #1;
    @(negedge inClk);
    outRun = 0; coreOut = 1; padIn = 1;
    repeat (2) @(posedge inClk);
    #1;
    chk("R6 output frozen", padOut, 1'b0);
    chk("R6 input live", coreIn, 1'b1);
    @(negedge inClk);
    outRun = 1;
    @(posedge inClk); #1;
    chk("R6 output resumes", padOut, 1'b1);

    // R9: asynchronous reset between edges
    @(negedge inClk);
    #5 rstN = 0; #1;
    chk("R9 async coreIn", coreIn, 1'b0);
    chk("R9 async padOut", padOut, 1'b0);
    @(negedge inClk);
    rstN = 1;
    @(posedge inClk); #1;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule